// File: doc/BRIEF.md
# Dispatch Port Allocator with Station Filtering

This block sits at the dispatch stage of an out-of-order core. Each cycle it is offered a group of micro-op slots. Each slot carries a valid bit, an exception flag, an operands-ready flag and a bitmask of the issue ports that can execute it. Fourteen issue ports feed reservation stations by default, one station per port. The mapping from port to station, the station-local port index, the station capacities and the per-cycle dispatch limits are all parameters.

The slots are handled in order, within one cycle. For each slot the block first drops every compatible port whose station is full. It also drops every port whose station has already taken its quota of micro-ops this cycle. Only then does it choose, from the ports that remain, the one with the smallest load weight. It bumps that port's weight and the station's occupancy.

When a slot has no port left, the input stalls at that slot. That slot and every slot after it are left unconsumed, and a saturating stall counter advances. A micro-op with an exception takes no port and is reported as commit-ready instead. Issue pulses from the execution side give back station entries and port weight.

Top module: `dport_alloc`

## Requirements
- R1: After reset no grant or commit-ready pulse is produced and the stall count is 0. All port weights and station occupancies start at zero, so the first allocation among several free ports goes to the lowest-numbered one.
- R2: A port whose station occupancy has reached that station's capacity is never chosen. The default capacities for stations 0 to 13 are 24, 26, 16, 12, 28, 28, 12, 12, 12, 12, 36, 36, 36, 36.
- R3: A port whose station has already accepted its dispatch quota earlier in the same cycle is skipped (default quota 1 per station). Counts restart every cycle, and exception slots do not count toward the quota.
- R4: A valid, non-exception slot with no eligible port is not consumed (slot_rdy low). No later slot of that cycle is consumed, in_stall is high, and stall_cnt rises by one at the next edge (saturating).
- R5: Among eligible ports the one with the lowest weight is chosen, ties going to the lowest port index. The chosen port's weight then rises by one.
- R6: Port weights saturate at their maximum (15 with the default 4-bit width) and never wrap below zero.
- R7: An issue pulse on a port lowers that port's weight and its station's occupancy by one, neither going below zero.
- R8: A valid exception slot that is not blocked is consumed without a port and pulses exc_done one cycle later. In that cycle it gets no grant.
- R9: A consumed non-exception slot produces, one cycle later, grant_vld with the chosen port, its station index, its station-local port index, and grant_opr equal to the slot's operands-ready flag (1 = ready queue, 0 = waiting).
- R10: An invalid slot is skipped: it is never consumed and does not block later slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | LANES | Slot holds a micro-op |
| slot_exc | input | LANES | Micro-op carries an exception |
| slot_opr | input | LANES | All operands of the micro-op are ready |
| slot_ports | input | LANES x NPORT | Compatible issue ports per slot, bit p = port p |
| issue_pulse | input | NPORT | One entry issued from port p this cycle |
| slot_rdy | output | LANES | Slot consumed this cycle |
| in_stall | output | 1 | Input stalled on a slot with no eligible port |
| grant_vld | output | LANES | Slot received a port (registered) |
| grant_port | output | LANES x PW | Chosen port index |
| grant_stn | output | LANES x SW | Station of the chosen port |
| grant_lport | output | LANES x LOC_W | Station-local index of the chosen port |
| grant_opr | output | LANES | Entry goes to the ready queue (1) or waits (0) |
| exc_done | output | LANES | Exception slot marked commit-ready (registered) |
| stall_cnt | output | STALL_W | Saturating count of stalled cycles |

## Verification
The bench fills a 12-entry station to its limit, then confirms two things: a wider mask moves on to a free station instead of stalling, and one issue pulse reopens the full station. A design that stalls on the first full port, or that never frees entries, fails here. Two slots aimed at the same station in one cycle expose a missing per-cycle quota, and a second mask with a free alternative catches an allocator that gives up early. Sequences of 16 grants and a release of an idle port catch weights that wrap past the maximum or below zero. Tied weights catch a wrong tie-break, and mixed invalid, blocked and exception slots catch slots that are wrongly consumed or wrongly allowed to block.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   // Index width for n items, at least one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Add one, holding at maxv.
   function automatic int unsigned sat_inc(input int unsigned v, input int unsigned maxv);
      return (v >= maxv) ? maxv : v + 1;
   endfunction

   // Subtract d, holding at zero.
   function automatic int unsigned floor_sub(input int unsigned v, input int unsigned d);
      return (d >= v) ? 0 : v - d;
   endfunction

endpackage

// File: rtl/dpa_lane.sv
// One dispatch slot: filters candidate ports against station capacity and
// the per-cycle quota, then picks the lightest port. Lanes are chained so
// a later slot sees the allocations of the earlier ones.
module dpa_lane
   import dpa_pkg::*;
#(
   parameter int unsigned NPORT   = 14,
   parameter int unsigned NSTN    = 14,
   parameter int unsigned OCC_W   = 6,
   parameter int unsigned DSP_W   = 2,
   parameter int unsigned WT_W    = 4,
   parameter int unsigned LOC_W   = 2,
   parameter int unsigned PORT_STN [NPORT] = '{default: 0},
   parameter int unsigned PORT_LOC [NPORT] = '{default: 0},
   parameter int unsigned STN_CAP  [NSTN]  = '{default: 1},
   parameter int unsigned STN_RATE [NSTN]  = '{default: 1},
   localparam int unsigned PW = idx_w(NPORT),
   localparam int unsigned SW = idx_w(NSTN)
) (
   input  logic              vld_i,
   input  logic              exc_i,
   input  logic              blk_i,
   input  logic [NPORT-1:0]  mask_i,
   input  logic [OCC_W-1:0]  occ_i [NSTN],
   input  logic [DSP_W-1:0]  dsp_i [NSTN],
   input  logic [WT_W-1:0]   wt_i  [NPORT],
   output logic              take_o,
   output logic              alloc_o,
   output logic              blk_o,
   output logic [PW-1:0]     pick_o,
   output logic [SW-1:0]     stn_o,
   output logic [LOC_W-1:0]  loc_o,
   output logic [OCC_W-1:0]  occ_o [NSTN],
   output logic [DSP_W-1:0]  dsp_o [NSTN],
   output logic [WT_W-1:0]   wt_o  [NPORT]
);

   localparam int unsigned WT_MAX = (1 << WT_W) - 1;

   logic [NPORT-1:0] elig;
   logic             found;
   logic [WT_W-1:0]  best_w;

   // Candidate filter: capacity and per-cycle quota of the mapped station.
   always_comb begin
      for (int p = 0; p < NPORT; p++) begin
         elig[p] = mask_i[p]
                   && (occ_i[PORT_STN[p]] < OCC_W'(STN_CAP[PORT_STN[p]]))
                   && (dsp_i[PORT_STN[p]] < DSP_W'(STN_RATE[PORT_STN[p]]));
      end
   end

   // Lowest weight wins; strict compare keeps the lowest index on ties.
   always_comb begin
      found  = 1'b0;
      best_w = '1;
      pick_o = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (elig[p] && (!found || wt_i[p] < best_w)) begin
            found  = 1'b1;
            best_w = wt_i[p];
            pick_o = PW'(p);
         end
      end
   end

   always_comb begin
      stn_o = '0;
      loc_o = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (pick_o == PW'(p)) begin
            stn_o = SW'(PORT_STN[p]);
            loc_o = LOC_W'(PORT_LOC[p]);
         end
      end
   end

   assign take_o  = vld_i && !blk_i && (exc_i || found);
   assign alloc_o = take_o && !exc_i;
   assign blk_o   = blk_i || (vld_i && !exc_i && !found);

   // Hand the updated bookkeeping to the next slot.
   always_comb begin
      for (int s = 0; s < NSTN; s++) begin
         if (alloc_o && stn_o == SW'(s)) begin
            occ_o[s] = occ_i[s] + 1'b1;
            dsp_o[s] = dsp_i[s] + 1'b1;
         end else begin
            occ_o[s] = occ_i[s];
            dsp_o[s] = dsp_i[s];
         end
      end
      for (int p = 0; p < NPORT; p++) begin
         if (alloc_o && pick_o == PW'(p))
            wt_o[p] = WT_W'(sat_inc(32'(wt_i[p]), WT_MAX));
         else
            wt_o[p] = wt_i[p];
      end
   end

endmodule

// File: rtl/dpa_occ_bank.sv
// Station occupancy registers: take the post-allocation values and apply
// the issue releases routed through the port-to-station map.
module dpa_occ_bank
   import dpa_pkg::*;
#(
   parameter int unsigned NPORT = 14,
   parameter int unsigned NSTN  = 14,
   parameter int unsigned OCC_W = 6,
   parameter int unsigned PORT_STN [NPORT] = '{default: 0},
   parameter int unsigned STN_CAP  [NSTN]  = '{default: 1}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ_upd [NSTN],
   input  logic [NPORT-1:0] issue_i,
   output logic [OCC_W-1:0] occ_q   [NSTN]
);

   logic [OCC_W-1:0] occ_d [NSTN];

   always_comb begin
      for (int s = 0; s < NSTN; s++) begin
         int unsigned rel;
         rel = 0;
         for (int p = 0; p < NPORT; p++) begin
            if (issue_i[p] && PORT_STN[p] == s) rel = rel + 1;
         end
         occ_d[s] = OCC_W'(floor_sub(32'(occ_upd[s]), rel));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NSTN; s++) occ_q[s] <= '0;
      end else begin
         for (int s = 0; s < NSTN; s++) occ_q[s] <= occ_d[s];
      end
   end

   for (genvar s = 0; s < NSTN; s++) begin : g_chk
      // R2: the filter keeps every station within its capacity
      a_r2_occ_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
         occ_q[s] <= OCC_W'(STN_CAP[s]));
   end

endmodule

// File: rtl/dpa_weight_bank.sv
// Per-port load weights with floor-at-zero release on issue.
module dpa_weight_bank
   import dpa_pkg::*;
#(
   parameter int unsigned NPORT = 14,
   parameter int unsigned WT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WT_W-1:0]  wt_upd [NPORT],
   input  logic [NPORT-1:0] issue_i,
   output logic [WT_W-1:0]  wt_q   [NPORT]
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NPORT; p++) wt_q[p] <= '0;
      end else begin
         for (int p = 0; p < NPORT; p++)
            wt_q[p] <= WT_W'(floor_sub(32'(wt_upd[p]), 32'(issue_i[p])));
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_chk
      // R6: a saturated weight with no release stays at the maximum
      a_r6_wt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(wt_q[p]) == '1 && !$past(issue_i[p])) |-> wt_q[p] == '1);
   end

endmodule

// File: rtl/dport_alloc.sv
module dport_alloc
   import dpa_pkg::*;
#(
   parameter int unsigned NPORT   = 14,
   parameter int unsigned NSTN    = 14,
   parameter int unsigned LANES   = 2,
   parameter int unsigned OCC_W   = 6,
   parameter int unsigned DSP_W   = 2,
   parameter int unsigned WT_W    = 4,
   parameter int unsigned LOC_W   = 2,
   parameter int unsigned STALL_W = 16,
   parameter int unsigned PORT_STN [NPORT] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13},
   parameter int unsigned PORT_LOC [NPORT] = '{default: 0},
   parameter int unsigned STN_CAP  [NSTN]  = '{24, 26, 16, 12, 28, 28, 12, 12, 12, 12, 36, 36, 36, 36},
   parameter int unsigned STN_RATE [NSTN]  = '{default: 1},
   localparam int unsigned PW = idx_w(NPORT),
   localparam int unsigned SW = idx_w(NSTN)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            slot_vld,
   input  logic [LANES-1:0]            slot_exc,
   input  logic [LANES-1:0]            slot_opr,
   input  logic [LANES-1:0][NPORT-1:0] slot_ports,
   input  logic [NPORT-1:0]            issue_pulse,
   output logic [LANES-1:0]            slot_rdy,
   output logic                        in_stall,
   output logic [LANES-1:0]            grant_vld,
   output logic [LANES-1:0][PW-1:0]    grant_port,
   output logic [LANES-1:0][SW-1:0]    grant_stn,
   output logic [LANES-1:0][LOC_W-1:0] grant_lport,
   output logic [LANES-1:0]            grant_opr,
   output logic [LANES-1:0]            exc_done,
   output logic [STALL_W-1:0]          stall_cnt
);

   // Elaboration-time parameter checks.
   initial begin
      assert (LANES >= 1) else $error("LANES must be at least 1");
      for (int p = 0; p < NPORT; p++) begin
         assert (PORT_STN[p] < NSTN) else $error("port %0d maps past last station", p);
         assert (PORT_LOC[p] < (1 << LOC_W)) else $error("port %0d local index too wide", p);
      end
      for (int s = 0; s < NSTN; s++) begin
         assert (STN_CAP[s] >= 1 && STN_CAP[s] < (1 << OCC_W))
            else $error("station %0d capacity out of range", s);
         assert (STN_RATE[s] >= 1 && STN_RATE[s] < (1 << DSP_W))
            else $error("station %0d quota out of range", s);
      end
   end

   logic [OCC_W-1:0] occ_q  [NSTN];
   logic [WT_W-1:0]  wt_q   [NPORT];

   logic [OCC_W-1:0] occ_li [LANES][NSTN];
   logic [OCC_W-1:0] occ_lo [LANES][NSTN];
   logic [DSP_W-1:0] dsp_li [LANES][NSTN];
   logic [DSP_W-1:0] dsp_lo [LANES][NSTN];
   logic [WT_W-1:0]  wt_li  [LANES][NPORT];
   logic [WT_W-1:0]  wt_lo  [LANES][NPORT];

   logic [LANES-1:0] blk_li, blk_lo, take, alloc;
   logic [PW-1:0]    pick  [LANES];
   logic [SW-1:0]    stn   [LANES];
   logic [LOC_W-1:0] loc   [LANES];

   // Slot chain: lane 0 starts from the registered state and a fresh quota.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_head
         assign occ_li[0] = occ_q;
         assign wt_li[0]  = wt_q;
         assign dsp_li[0] = '{default: '0};
         assign blk_li[0] = 1'b0;
      end else begin : g_link
         assign occ_li[l] = occ_lo[l-1];
         assign wt_li[l]  = wt_lo[l-1];
         assign dsp_li[l] = dsp_lo[l-1];
         assign blk_li[l] = blk_lo[l-1];
      end

      dpa_lane #(
         .NPORT(NPORT), .NSTN(NSTN), .OCC_W(OCC_W), .DSP_W(DSP_W),
         .WT_W(WT_W), .LOC_W(LOC_W),
         .PORT_STN(PORT_STN), .PORT_LOC(PORT_LOC),
         .STN_CAP(STN_CAP), .STN_RATE(STN_RATE)
      ) u_lane (
         .vld_i   (slot_vld[l]),
         .exc_i   (slot_exc[l]),
         .blk_i   (blk_li[l]),
         .mask_i  (slot_ports[l]),
         .occ_i   (occ_li[l]),
         .dsp_i   (dsp_li[l]),
         .wt_i    (wt_li[l]),
         .take_o  (take[l]),
         .alloc_o (alloc[l]),
         .blk_o   (blk_lo[l]),
         .pick_o  (pick[l]),
         .stn_o   (stn[l]),
         .loc_o   (loc[l]),
         .occ_o   (occ_lo[l]),
         .dsp_o   (dsp_lo[l]),
         .wt_o    (wt_lo[l])
      );
   end

   dpa_occ_bank #(
      .NPORT(NPORT), .NSTN(NSTN), .OCC_W(OCC_W),
      .PORT_STN(PORT_STN), .STN_CAP(STN_CAP)
   ) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .occ_upd (occ_lo[LANES-1]),
      .issue_i (issue_pulse),
      .occ_q   (occ_q)
   );

   dpa_weight_bank #(
      .NPORT(NPORT), .WT_W(WT_W)
   ) u_wt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wt_upd  (wt_lo[LANES-1]),
      .issue_i (issue_pulse),
      .wt_q    (wt_q)
   );

   assign slot_rdy = take;
   assign in_stall = blk_lo[LANES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_vld   <= '0;
         grant_port  <= '0;
         grant_stn   <= '0;
         grant_lport <= '0;
         grant_opr   <= '0;
         exc_done    <= '0;
         stall_cnt   <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            grant_vld[l]   <= alloc[l];
            grant_port[l]  <= pick[l];
            grant_stn[l]   <= stn[l];
            grant_lport[l] <= loc[l];
            grant_opr[l]   <= alloc[l] && slot_opr[l];
            exc_done[l]    <= take[l] && slot_exc[l];
         end
         if (in_stall && stall_cnt != '1) stall_cnt <= stall_cnt + 1'b1;
      end
   end

   // R4: a stall always leaves some valid slot unconsumed
   a_r4_stall_leaves_slot: assert property (@(posedge clk) disable iff (!rst_n)
      in_stall |-> (slot_vld & ~slot_rdy) != '0);

   // R4: each stalled cycle advances the counter by one until saturation
   a_r4_stall_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_stall) && $past(stall_cnt) != '1)
      |-> stall_cnt == $past(stall_cnt) + 1'b1);

   for (genvar l = 0; l < LANES; l++) begin : g_chk
      // R9: a grant follows a consumed non-exception slot
      a_r9_grant_from_take: assert property (@(posedge clk) disable iff (!rst_n)
         grant_vld[l] |-> $past(slot_rdy[l] && !slot_exc[l]));
      // R8: an exception slot never receives a port
      a_r8_exc_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
         exc_done[l] |-> !grant_vld[l]);
      // R10: an empty slot is never consumed
      a_r10_idle_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
         !slot_vld[l] |-> !slot_rdy[l]);
   end

endmodule

// File: tb/dport_alloc_tb_top.sv
module dport_alloc_tb_top;

   localparam int CLK_P = 10;
   localparam int WD_CYC = 20000;

   logic clk = 1'b0;
   logic rst_n;
   always #(CLK_P/2) clk = ~clk;

   logic [1:0]       slot_vld, slot_exc, slot_opr;
   logic [1:0][13:0] slot_ports;
   logic [13:0]      issue_pulse;
   logic [1:0]       slot_rdy;
   logic             in_stall;
   logic [1:0]       grant_vld;
   logic [1:0][3:0]  grant_port;
   logic [1:0][3:0]  grant_stn;
   logic [1:0][1:0]  grant_lport;
   logic [1:0]       grant_opr;
   logic [1:0]       exc_done;
   logic [15:0]      stall_cnt;

   dport_alloc dut_i (
      .clk(clk), .rst_n(rst_n),
      .slot_vld(slot_vld), .slot_exc(slot_exc), .slot_opr(slot_opr),
      .slot_ports(slot_ports), .issue_pulse(issue_pulse),
      .slot_rdy(slot_rdy), .in_stall(in_stall),
      .grant_vld(grant_vld), .grant_port(grant_port), .grant_stn(grant_stn),
      .grant_lport(grant_lport), .grant_opr(grant_opr),
      .exc_done(exc_done), .stall_cnt(stall_cnt)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   logic [1:0] s_rdy;
   logic       s_stall;

   function automatic logic [13:0] pm(input int a);
      return 14'(1) << a;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      slot_vld = '0; slot_exc = '0; slot_opr = '0;
      slot_ports = '0; issue_pulse = '0;
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // Drive one cycle of stimulus; sample handshake before the edge and
   // registered outputs just after it.
   task automatic step(input logic [1:0] v, input logic [1:0] e, input logic [1:0] o,
                       input logic [13:0] m0, input logic [13:0] m1, input logic [13:0] is);
      slot_vld = v; slot_exc = e; slot_opr = o;
      slot_ports[0] = m0; slot_ports[1] = m1; issue_pulse = is;
      #1;
      s_rdy = slot_rdy;
      s_stall = in_stall;
      @(posedge clk);
      #1;
      idle_inputs();
   endtask

   task automatic t_reset();
      do_reset();
      #2;
      chk(grant_vld == 2'b00 && exc_done == 2'b00, "R1 no grant after reset", int'(grant_vld), 0);
      chk(stall_cnt == 0, "R1 stall count cleared", int'(stall_cnt), 0);
   endtask

   task automatic t_weights();
      int exp_p [4] = '{2, 5, 9, 2};
      do_reset();
      for (int i = 0; i < 4; i++) begin
         step(2'b01, 2'b00, 2'b00, pm(2) | pm(5) | pm(9), '0, '0);
         chk(grant_vld[0] && grant_port[0] == 4'(exp_p[i]), "R5 lightest port, low index on tie",
             int'(grant_port[0]), exp_p[i]);
      end
      chk(grant_stn[0] == 4'd2 && grant_lport[0] == 2'd0, "R9 station and local index",
          int'(grant_stn[0]), 2);
   endtask

   task automatic t_quota();
      do_reset();
      step(2'b11, 2'b00, 2'b00, pm(4), pm(4), '0);
      chk(s_rdy == 2'b01 && s_stall, "R3 second slot to same station blocked", int'(s_rdy), 1);
      chk(grant_vld == 2'b01 && grant_port[0] == 4'd4, "R3 first slot granted", int'(grant_vld), 1);
      chk(stall_cnt == 16'd1, "R4 stall counter", int'(stall_cnt), 1);
      step(2'b11, 2'b00, 2'b00, pm(4), pm(4) | pm(7), '0);
      chk(s_rdy == 2'b11 && !s_stall, "R3 alternative port keeps flow", int'(s_rdy), 3);
      chk(grant_port[0] == 4'd4 && grant_port[1] == 4'd7, "R3 quota skips to port 7",
          int'(grant_port[1]), 7);
   endtask

   task automatic t_capacity();
      int ok_cnt = 0;
      do_reset();
      for (int i = 0; i < 12; i++) begin
         step(2'b01, 2'b00, 2'b00, pm(3), '0, '0);
         if (grant_vld[0] && grant_port[0] == 4'd3) ok_cnt++;
      end
      chk(ok_cnt == 12, "R2 twelve entries accepted", ok_cnt, 12);
      step(2'b01, 2'b00, 2'b00, pm(3), '0, '0);
      chk(s_rdy == 2'b00 && s_stall, "R2 full station stalls", int'(s_rdy), 0);
      chk(grant_vld == 2'b00, "R2 no grant when full", int'(grant_vld), 0);
      step(2'b01, 2'b00, 2'b00, pm(3) | pm(6), '0, '0);
      chk(grant_vld[0] && grant_port[0] == 4'd6, "R2 full port filtered, port 6 used",
          int'(grant_port[0]), 6);
      step(2'b00, 2'b00, 2'b00, '0, '0, pm(3));
      step(2'b01, 2'b00, 2'b00, pm(3), '0, '0);
      chk(grant_vld[0] && grant_port[0] == 4'd3, "R7 issue frees station entry",
          int'(grant_port[0]), 3);
   endtask

   task automatic t_saturation();
      do_reset();
      for (int i = 0; i < 16; i++) step(2'b01, 2'b00, 2'b00, pm(10), '0, '0);
      step(2'b01, 2'b00, 2'b00, pm(11), '0, '0);
      step(2'b01, 2'b00, 2'b00, pm(10) | pm(11), '0, '0);
      chk(grant_vld[0] && grant_port[0] == 4'd11, "R6 weight holds at maximum",
          int'(grant_port[0]), 11);
   endtask

   task automatic t_floor();
      do_reset();
      step(2'b00, 2'b00, 2'b00, '0, '0, pm(12));
      step(2'b01, 2'b00, 2'b00, pm(12) | pm(13), '0, '0);
      chk(grant_vld[0] && grant_port[0] == 4'd12, "R7 release at zero does not wrap",
          int'(grant_port[0]), 12);
   endtask

   task automatic t_exception();
      do_reset();
      step(2'b11, 2'b01, 2'b10, pm(0), pm(0), '0);
      chk(s_rdy == 2'b11, "R8 exception slot consumed", int'(s_rdy), 3);
      chk(exc_done == 2'b01 && !grant_vld[0], "R8 commit-ready without port", int'(exc_done), 1);
      chk(grant_vld[1] && grant_port[1] == 4'd0, "R3 exception takes no quota",
          int'(grant_port[1]), 0);
      chk(grant_opr[1] == 1'b1 && grant_stn[1] == 4'd0, "R9 ready flag forwarded",
          int'(grant_opr[1]), 1);
      step(2'b01, 2'b00, 2'b00, pm(1), '0, '0);
      chk(grant_vld[0] && grant_opr[0] == 1'b0, "R9 waiting flag forwarded", int'(grant_opr[0]), 0);
   endtask

   task automatic t_order();
      do_reset();
      step(2'b11, 2'b00, 2'b00, '0, pm(1), '0);
      chk(s_rdy == 2'b00 && s_stall, "R4 blocked slot holds later slot", int'(s_rdy), 0);
      chk(grant_vld == 2'b00, "R4 nothing dispatched", int'(grant_vld), 0);
      step(2'b10, 2'b00, 2'b00, pm(0), pm(1), '0);
      chk(s_rdy == 2'b10 && !s_stall, "R10 empty slot skipped", int'(s_rdy), 2);
      chk(grant_vld == 2'b10 && grant_port[1] == 4'd1, "R10 later slot granted",
          int'(grant_port[1]), 1);
   endtask

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      t_reset();
      t_weights();
      t_quota();
      t_capacity();
      t_saturation();
      t_floor();
      t_exception();
      t_order();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog all-requirements actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule